// File: doc/BRIEF.md
# Three-Beat RGB Pixel Assembler

This block receives pixels from a display controller over a 6-bit parallel data bus that runs on the dot clock. Each 18-bit pixel arrives in three transfers, one colour per transfer, always red first, then green, then blue. The block counts the transfers, keeps the first two colours, and joins all three into one 18-bit pixel word. When the last colour of a pixel is taken, the block raises a one-cycle write strobe toward the frame memory. Six bits per channel gives 262,144 colours.

A transfer counts only on a dot-clock edge where both the data-valid and data-enable inputs are high. At each frame start, which is the falling edge of vertical sync, the transfer counter is forced back to the red beat. A dropped or extra transfer can then damage the colour order only for the rest of that frame. The next frame starts in the correct order with no other recovery step. A debug pulse reports each frame start that found the counter away from red.

The beat sequencer is a three-state machine. The states are `BEAT_RED`, `BEAT_GRN` and `BEAT_BLU`. It has these transitions:
- ADVANCE: RED to GRN, or GRN to BLU, on an accepted transfer.
- WRAP: BLU to RED, on an accepted transfer, which completes a pixel.
- REALIGN: any state to RED on a vertical-sync falling edge with no transfer in that cycle.
- REALIGN+ADVANCE: any state to GRN, when a falling edge and an accepted transfer fall in the same cycle.
- HOLD: the state stays the same in any other cycle.

Top module: `rgb_pixel_assembler`

## Requirements
- R1: A completed pixel is packed with red in pixel_o[17:12], green in pixel_o[11:6] and blue in pixel_o[5:0]. The three colours come from three accepted transfers in the order red, green, blue.
- R2: A transfer is accepted only on a clock edge where valid_i and enable_i are both 1. On any other edge the beat counter and the stored colours stay unchanged.
- R3: pixel_valid_o goes high for exactly one cycle, in the cycle after the blue transfer is accepted. pixel_o takes the new pixel in that same cycle and holds its value at all other times.
- R4: A vertical-sync falling edge is detected when vsync_i is sampled as 1 on one edge and as 0 on the next edge. It returns the beat counter to red, whatever state the counter is in.
- R5: When a falling edge and an accepted transfer occur on the same edge, that transfer is the red beat of the new frame.
- R6: misalign_o goes high for one cycle, in the cycle after a falling edge that found the counter on green or blue. It stays low after a falling edge that found the counter on red.
- R7: While rst_n_i is low at a clock edge, the counter goes to red, and pixel_valid_o, misalign_o and pixel_o go to 0. The previous vsync sample is also cleared.
- R8: A rising edge of vsync_i, or a steady vsync_i level, has no effect on the beat counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| vsync_i | input | 1 | Vertical sync; its falling edge marks a frame start |
| valid_i | input | 1 | Data-valid qualifier, active high |
| enable_i | input | 1 | Data-enable qualifier, active high |
| data_i | input | 6 | One colour channel per transfer |
| pixel_o | output | 18 | Assembled pixel {red, green, blue} |
| pixel_valid_o | output | 1 | One-cycle write strobe for a completed pixel |
| misalign_o | output | 1 | Pulse: a frame started with the counter away from red |

## Verification
The hardest case to reach from the ports is a frame start that finds the counter on green or blue, made worse when a qualified transfer lands on that same edge. To get there, the stimulus must first leave the counter partway through a pixel and then lower vsync_i on exactly the chosen edge. Directed sequences create this case for each counter state, both with and without a transfer on the edge. Random stimulus then drops beats, gates valid_i and enable_i independently, and toggles vsync_i often enough that misaligned frame starts happen many times.

// File: rtl/rgb_asm_pkg.sv
package rgb_asm_pkg;
    parameter int COLOR_W   = 6;
    parameter int NUM_BEATS = 3;
    localparam int PIX_W    = COLOR_W * NUM_BEATS;

    typedef enum logic [1:0] {
        BEAT_RED = 2'd0,
        BEAT_GRN = 2'd1,
        BEAT_BLU = 2'd2
    } beat_e;
endpackage

// File: rtl/rgb_vsync_edge.sv
module rgb_vsync_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic vsync_i,
    output logic fall_o
);
    logic vsync_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) vsync_q <= 1'b0;
        else          vsync_q <= vsync_i;
    end

    assign fall_o = vsync_q & ~vsync_i;

    // Edge flag only when the registered copy was high.
    AST_FALL_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        fall_o |-> $past(vsync_i)) else $error("fall without prior high"); // R4
endmodule

// File: rtl/rgb_beat_fsm.sv
module rgb_beat_fsm
    import rgb_asm_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_n_i,
    input  logic  fall_i,
    input  logic  accept_i,
    output beat_e beat_o,
    output logic  last_o,
    output logic  misalign_o
);
    beat_e state_q;
    beat_e state_d;
    beat_e eff_beat;
    logic  misalign_q;

    // Effective beat for this edge: a frame start realigns to red first.
    assign eff_beat = fall_i ? BEAT_RED : state_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= BEAT_RED;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = eff_beat;
        if (accept_i) begin
            unique case (eff_beat)
                BEAT_RED: state_d = BEAT_GRN;
                BEAT_GRN: state_d = BEAT_BLU;
                BEAT_BLU: state_d = BEAT_RED;
                default:  state_d = BEAT_RED;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) misalign_q <= 1'b0;
        else          misalign_q <= fall_i && (state_q != BEAT_RED);
    end

    assign beat_o     = eff_beat;
    assign last_o     = accept_i && (eff_beat == BEAT_BLU);
    assign misalign_o = misalign_q;

    AST_FALL_TO_RED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (fall_i && !accept_i) |=> (state_q == BEAT_RED)) else $error("no realign"); // R4
    AST_FALL_ACCEPT_GRN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (fall_i && accept_i) |=> (state_q == BEAT_GRN)) else $error("same-edge beat not red"); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!fall_i && !accept_i) |=> $stable(state_q)) else $error("counter moved when idle"); // R2
endmodule

// File: rtl/rgb_pixel_pack.sv
module rgb_pixel_pack
    import rgb_asm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               accept_i,
    input  beat_e              beat_i,
    input  logic               last_i,
    input  logic [COLOR_W-1:0] data_i,
    output logic [PIX_W-1:0]   pixel_o,
    output logic               pixel_valid_o
);
    localparam int NUM_PART = NUM_BEATS - 1;

    logic [COLOR_W-1:0] part_q [NUM_PART];
    logic [PIX_W-1:0]   pixel_q;
    logic               pv_q;

    // One holding register per colour that precedes the final beat.
    for (genvar g = 0; g < NUM_PART; g++) begin : g_part
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                part_q[g] <= '0;
            else if (accept_i && (beat_i == beat_e'(g)))
                part_q[g] <= data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            pixel_q <= '0;
            pv_q    <= 1'b0;
        end else begin
            pv_q <= last_i;
            if (last_i) pixel_q <= {part_q[0], part_q[1], data_i};
        end
    end

    assign pixel_o       = pixel_q;
    assign pixel_valid_o = pv_q;

    AST_PV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pixel_valid_o |=> !pixel_valid_o) else $error("strobe longer than one cycle"); // R3
    AST_PIXEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !last_i |=> $stable(pixel_o)) else $error("pixel changed without strobe"); // R3
endmodule

// File: rtl/rgb_pixel_assembler.sv
module rgb_pixel_assembler
    import rgb_asm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               vsync_i,
    input  logic               valid_i,
    input  logic               enable_i,
    input  logic [COLOR_W-1:0] data_i,
    output logic [PIX_W-1:0]   pixel_o,
    output logic               pixel_valid_o,
    output logic               misalign_o
);
    logic  fall;
    logic  accept;
    logic  last;
    beat_e beat;

    assign accept = valid_i & enable_i;

    rgb_vsync_edge u_edge (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .vsync_i (vsync_i),
        .fall_o  (fall)
    );

    rgb_beat_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .fall_i     (fall),
        .accept_i   (accept),
        .beat_o     (beat),
        .last_o     (last),
        .misalign_o (misalign_o)
    );

    rgb_pixel_pack u_pack (
        .clk_i         (clk_i),
        .rst_n_i       (rst_n_i),
        .accept_i      (accept),
        .beat_i        (beat),
        .last_i        (last),
        .data_i        (data_i),
        .pixel_o       (pixel_o),
        .pixel_valid_o (pixel_valid_o)
    );

    AST_PV_NEEDS_QUAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pixel_valid_o |-> $past(valid_i && enable_i)) else $error("strobe without qualified beat"); // R2
    AST_MIS_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        misalign_o |-> ($past(vsync_i, 2) && !$past(vsync_i))) else $error("misalign without frame start"); // R6
endmodule

// File: tb/rgb_pixel_assembler_tb.sv
`timescale 1ns/1ps
module rgb_pixel_assembler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vsync, valid, enable;
    logic [5:0]  data;
    logic [17:0] pixel;
    logic        pv, mis;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    logic        m_prev_vs;
    int          m_beat;
    logic [5:0]  m_r, m_g;
    logic [17:0] m_pix;
    logic        m_pv, m_mis;

    always #4 clk = ~clk;

    rgb_pixel_assembler dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .vsync_i(vsync), .valid_i(valid),
        .enable_i(enable), .data_i(data), .pixel_o(pixel),
        .pixel_valid_o(pv), .misalign_o(mis)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_prev_vs = 1'b0; m_beat = 0; m_r = '0; m_g = '0;
        m_pix = '0; m_pv = 1'b0; m_mis = 1'b0;
    endfunction

    function automatic void model_step(logic vs, logic v, logic e, logic [5:0] d);
        logic fall;
        logic q;
        int   eff;
        fall  = m_prev_vs && !vs;
        eff   = fall ? 0 : m_beat;
        q     = v && e;
        m_mis = fall && (m_beat != 0);
        m_pv  = q && (eff == 2);
        if (q) begin
            if (eff == 0)      m_r = d;
            else if (eff == 1) m_g = d;
            else               m_pix = {m_r, m_g, d};
            m_beat = (eff == 2) ? 0 : eff + 1;
        end else begin
            m_beat = eff;
        end
        m_prev_vs = vs;
    endfunction

    // Called at a falling clock edge; returns at the next falling edge.
    task automatic step(string tag, logic vs, logic v, logic e, logic [5:0] d);
        vsync = vs; valid = v; enable = e; data = d;
        model_step(vs, v, e, d);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " pixel_valid"}, 32'(pv), 32'(m_pv));
        chk({tag, " pixel"}, 32'(pixel), 32'(m_pix));
        chk({tag, " misalign"}, 32'(mis), 32'(m_mis));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst_n = 1'b0; vsync = 1'b1; valid = 1'b1; enable = 1'b1; data = 6'h3f;
        model_reset();
        repeat (3) @(negedge clk);
        // R7: reset values
        chk("R7 pixel_valid", 32'(pv), 0);
        chk("R7 misalign", 32'(mis), 0);
        chk("R7 pixel", 32'(pixel), 0);
        rst_n = 1'b1;

        // R1: plain pixel, red/green/blue field placement
        step("R1", 1, 1, 1, 6'h2a);
        step("R1", 1, 1, 1, 6'h15);
        step("R1", 1, 1, 1, 6'h3c);
        chk("R1 packed", 32'(pixel), 32'({6'h2a, 6'h15, 6'h3c}));

        // R2: only one qualifier high, no effect
        step("R2", 1, 1, 1, 6'h01);
        step("R2", 1, 1, 0, 6'h3f);
        step("R2", 1, 0, 1, 6'h3e);
        step("R2", 1, 0, 0, 6'h3d);
        step("R2", 1, 1, 1, 6'h02);
        step("R2", 1, 1, 1, 6'h03);
        chk("R2 gated beats ignored", 32'(pixel), 32'({6'h01, 6'h02, 6'h03}));
        // R3: strobe dropped after one cycle, pixel held
        step("R3", 1, 0, 0, 6'h00);
        chk("R3 strobe single", 32'(pv), 0);

        // R8: vsync rise mid-pixel does not move the counter
        step("R8", 0, 1, 1, 6'h11);
        step("R8", 1, 1, 1, 6'h12);
        step("R8", 1, 1, 1, 6'h13);
        chk("R8 pixel after rise", 32'(pixel), 32'({6'h11, 6'h12, 6'h13}));

        // R4/R6: frame start found counter on green
        step("R4", 1, 1, 1, 6'h21);
        step("R4", 0, 0, 0, 6'h00);
        chk("R6 misalign on green", 32'(mis), 1);
        step("R4", 0, 1, 1, 6'h05);
        step("R4", 0, 1, 1, 6'h06);
        step("R4", 0, 1, 1, 6'h07);
        chk("R4 realigned pixel", 32'(pixel), 32'({6'h05, 6'h06, 6'h07}));

        // R6: frame start found counter on red, no pulse
        step("R6", 1, 0, 0, 6'h00);
        step("R6", 0, 0, 0, 6'h00);
        chk("R6 no misalign on red", 32'(mis), 0);

        // R5: fall on blue with a beat on the same edge
        step("R5", 1, 1, 1, 6'h31);
        step("R5", 1, 1, 1, 6'h32);
        step("R5", 0, 1, 1, 6'h33);
        chk("R5 no strobe on realigned beat", 32'(pv), 0);
        chk("R5 misalign on blue", 32'(mis), 1);
        step("R5", 0, 1, 1, 6'h34);
        step("R5", 0, 1, 1, 6'h35);
        chk("R5 strobe", 32'(pv), 1);
        chk("R5 pixel", 32'(pixel), 32'({6'h33, 6'h34, 6'h35}));

        // random stimulus: all requirements against the bench model
        for (int i = 0; i < 4000; i++) begin
            logic vs;
            vs = ($urandom % 16 == 0) ? ~vsync : vsync;
            step("R1..random", vs, ($urandom % 4) != 0, ($urandom % 5) != 0, 6'($urandom));
        end

        // reset in the middle of a pixel
        step("R7", 1, 1, 1, 6'h0a);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        chk("R7 mid reset pv", 32'(pv), 0);
        step("R7", 1, 1, 1, 6'h0b);
        step("R7", 1, 1, 1, 6'h0c);
        step("R7", 1, 1, 1, 6'h0d);
        chk("R7 counter cleared", 32'(pixel), 32'({6'h0b, 6'h0c, 6'h0d}));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule